// File: doc/BRIEF.md
# Drive Timing Configuration Unlock and Programmer

This block holds the drive strobe timing (active and recovery lengths, in clocks) and a small feature register for a two-channel disk host adapter. While reset is held, two strap inputs pick one of four default timing pairs and a third strap picks the primary or secondary channel; the values present in the last reset cycle are the ones kept.

After reset, software reprograms the timing by reading the feature port 3E6h four times in a row. That arms a configuration mode. In this mode a byte written to the selected channel's head register port is captured as timing data and is not forwarded to the drive. A single read of that channel's status port leaves the mode again. The block classifies each host I/O access, one per clock, and reports whether a head-port write must go through to the drive.

Top module: `cfg_timing_prog`

## Requirements
- R1: While `rst` is high the timing tracks the straps `strap_a`,`strap_b` (given in that order): 00 gives 15/15 active/recovery clocks, 10 gives 10/10, 01 gives 7/7, 11 gives 4/4; the value seen in the last reset cycle is held after release.
- R2: At reset `port_sec` takes `strap_sec`, and `fifo_en` and `prefetch_en` clear to 0.
- R3: The fourth consecutive read of port 3E6h sets `cfg_mode` one clock after that read's cycle; fewer reads leave it clear.
- R4: Any access other than a read of 3E6h, seen before the fourth such read, restarts the count at zero, so four further reads are needed.
- R5: In configuration mode a write to the selected head port (1F6h when `port_sec`=0, 176h when 1) loads recovery from data bits 7:4 and active from bits 3:0 one clock later, and `head_wr_pass` stays 0 for it.
- R6: A timing code of 2 to 15 gives that many clocks; codes 0 and 1 both give 16 clocks, so outputs always lie in 2..16.
- R7: In configuration mode one read of the selected status port (1F7h or 177h) clears `cfg_mode` one clock later.
- R8: Outside configuration mode a write to the selected head port raises `head_wr_pass` in the same cycle and leaves the timing unchanged.
- R9: A write to 3E6h loads `port_sec` from bit 0, `fifo_en` from bit 2 and `prefetch_en` from bit 5; a read of 3E6h returns these bits at the same positions on `rd_data` with all other bits 0, and `rd_data` is 0 for any other cycle.
- R10: Head and status ports of the non-selected channel neither capture timing nor leave configuration mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; straps sampled while high |
| strap_a | input | 1 | First timing strap |
| strap_b | input | 1 | Second timing strap |
| strap_sec | input | 1 | Channel select strap (1 = secondary) |
| acc_valid | input | 1 | A host I/O access is present this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 10 | I/O port address |
| acc_wdata | input | 8 | Write data byte |
| rd_data | output | 8 | Feature register image during a 3E6h read, else 0 |
| head_wr_pass | output | 1 | Head-port write is forwarded to the drive |
| cfg_mode | output | 1 | Configuration mode is armed |
| act_clks | output | 5 | Active strobe length in clocks (2..16) |
| rec_clks | output | 5 | Recovery length in clocks (2..16) |
| port_sec | output | 1 | Selected channel (1 = secondary) |
| fifo_en | output | 1 | FIFO enable feature bit |
| prefetch_en | output | 1 | Prefetch-read enable feature bit |

## Verification
The assertions assume one access per clock with `acc_write`, `acc_addr` and `acc_wdata` meaningful only while `acc_valid` is high, and straps that are steady apart from the reset window. The stimulus changes inputs only on the falling edge, holds each access for exactly one clock, and moves straps only while `rst` is asserted. Unlock sequences are interrupted by foreign accesses and by a read counted before the feature write, so the counter's restart rule is driven from several states.

// File: rtl/cfgprog_pkg.sv
package cfgprog_pkg;

    localparam int ADDR_W = 10;
    localparam int DATA_W = 8;
    localparam int CODE_W = 4;
    localparam int CLK_W  = CODE_W + 1;

    localparam logic [ADDR_W-1:0] FEAT_PORT = 10'h3E6;
    localparam logic [ADDR_W-1:0] HEAD_PRI  = 10'h1F6;
    localparam logic [ADDR_W-1:0] HEAD_SEC  = 10'h176;
    localparam logic [ADDR_W-1:0] STAT_PRI  = 10'h1F7;
    localparam logic [ADDR_W-1:0] STAT_SEC  = 10'h177;

    localparam int FEAT_SEC_BIT  = 0;
    localparam int FEAT_FIFO_BIT = 2;
    localparam int FEAT_PREF_BIT = 5;

    typedef enum logic [2:0] {
        ACC_IDLE,
        ACC_FEAT_RD,
        ACC_FEAT_WR,
        ACC_HEAD_WR,
        ACC_STAT_RD,
        ACC_OTHER
    } acc_kind_e;

    typedef struct packed {
        logic              valid;
        logic              write;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } host_acc_t;

    typedef struct packed {
        logic [CLK_W-1:0] act;
        logic [CLK_W-1:0] rec;
    } timing_t;

    typedef struct packed {
        logic prefetch;
        logic fifo;
        logic sec;
    } feature_t;

    function automatic logic [CLK_W-1:0] code_to_clks(input logic [CODE_W-1:0] code);
        if (code <= CODE_W'(1))
            return CLK_W'(16);
        return {1'b0, code};
    endfunction

    function automatic timing_t strap_timing(input logic a, input logic b);
        timing_t t;
        unique case ({a, b})
            2'b00:   t.act = CLK_W'(15);
            2'b10:   t.act = CLK_W'(10);
            2'b01:   t.act = CLK_W'(7);
            default: t.act = CLK_W'(4);
        endcase
        t.rec = t.act;
        return t;
    endfunction

    function automatic logic [DATA_W-1:0] feature_image(input feature_t f);
        logic [DATA_W-1:0] v;
        v = '0;
        v[FEAT_SEC_BIT]  = f.sec;
        v[FEAT_FIFO_BIT] = f.fifo;
        v[FEAT_PREF_BIT] = f.prefetch;
        return v;
    endfunction

endpackage

// File: rtl/cfgprog_decode.sv
module cfgprog_decode
    import cfgprog_pkg::*;
(
    input  host_acc_t acc,
    input  logic      port_sec,
    output acc_kind_e kind
);
    logic [ADDR_W-1:0] head_port;
    logic [ADDR_W-1:0] stat_port;

    always_comb begin
        head_port = port_sec ? HEAD_SEC : HEAD_PRI;
        stat_port = port_sec ? STAT_SEC : STAT_PRI;
        if (!acc.valid)
            kind = ACC_IDLE;
        else if (acc.addr == FEAT_PORT)
            kind = acc.write ? ACC_FEAT_WR : ACC_FEAT_RD;
        else if (acc.write && acc.addr == head_port)
            kind = ACC_HEAD_WR;
        else if (!acc.write && acc.addr == stat_port)
            kind = ACC_STAT_RD;
        else
            kind = ACC_OTHER;
    end
endmodule

// File: rtl/cfgprog_unlock.sv
module cfgprog_unlock
    import cfgprog_pkg::*;
#(
    parameter int UNLOCK_READS = 4
) (
    input  logic      clk,
    input  logic      rst,
    input  acc_kind_e kind,
    output logic      cfg_mode
);
    localparam int CNT_W = $clog2(UNLOCK_READS + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(UNLOCK_READS - 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt      <= '0;
            cfg_mode <= 1'b0;
        end else if (kind != ACC_IDLE) begin
            if (cfg_mode) begin
                cnt <= '0;
                if (kind == ACC_STAT_RD)
                    cfg_mode <= 1'b0;
            end else if (kind == ACC_FEAT_RD) begin
                if (cnt == LAST) begin
                    cnt      <= '0;
                    cfg_mode <= 1'b1;
                end else begin
                    cnt <= cnt + CNT_W'(1);
                end
            end else begin
                cnt <= '0;
            end
        end
    end

    p_cnt_range_r3: assert property (@(posedge clk) disable iff (rst)
        cnt <= LAST);

    p_enter_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(cfg_mode) |-> $past(kind == ACC_FEAT_RD));

    p_cnt_clear_r4: assert property (@(posedge clk) disable iff (rst)
        (kind != ACC_IDLE && kind != ACC_FEAT_RD) |=> (cnt == '0));

    p_exit_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(cfg_mode) |-> $past(kind == ACC_STAT_RD));
endmodule

// File: rtl/cfgprog_timing.sv
module cfgprog_timing
    import cfgprog_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              strap_a,
    input  logic              strap_b,
    input  logic              capture,
    input  logic [DATA_W-1:0] wdata,
    output timing_t           timing
);
    timing_t next_t;

    always_comb begin
        next_t.rec = code_to_clks(wdata[2*CODE_W-1:CODE_W]);
        next_t.act = code_to_clks(wdata[CODE_W-1:0]);
    end

    always_ff @(posedge clk) begin
        if (rst)
            timing <= strap_timing(strap_a, strap_b);
        else if (capture)
            timing <= next_t;
    end

    p_clk_range_r6: assert property (@(posedge clk) disable iff (rst)
        timing.act >= CLK_W'(2) && timing.act <= CLK_W'(16) &&
        timing.rec >= CLK_W'(2) && timing.rec <= CLK_W'(16));
endmodule

// File: rtl/cfgprog_feature.sv
module cfgprog_feature
    import cfgprog_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              strap_sec,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    output feature_t          feat
);
    always_ff @(posedge clk) begin
        if (rst) begin
            feat.sec      <= strap_sec;
            feat.fifo     <= 1'b0;
            feat.prefetch <= 1'b0;
        end else if (wr) begin
            feat.sec      <= wdata[FEAT_SEC_BIT];
            feat.fifo     <= wdata[FEAT_FIFO_BIT];
            feat.prefetch <= wdata[FEAT_PREF_BIT];
        end
    end

    p_feat_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !wr |=> $stable(feat));
endmodule

// File: rtl/cfg_timing_prog.sv
module cfg_timing_prog
    import cfgprog_pkg::*;
#(
    parameter int UNLOCK_READS = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        strap_a,
    input  logic        strap_b,
    input  logic        strap_sec,
    input  logic        acc_valid,
    input  logic        acc_write,
    input  logic [9:0]  acc_addr,
    input  logic [7:0]  acc_wdata,
    output logic [7:0]  rd_data,
    output logic        head_wr_pass,
    output logic        cfg_mode,
    output logic [4:0]  act_clks,
    output logic [4:0]  rec_clks,
    output logic        port_sec,
    output logic        fifo_en,
    output logic        prefetch_en
);
    host_acc_t acc;
    acc_kind_e kind;
    timing_t   timing;
    feature_t  feat;

    assign acc = '{valid: acc_valid, write: acc_write, addr: acc_addr, wdata: acc_wdata};

    cfgprog_decode u_decode (
        .acc      (acc),
        .port_sec (feat.sec),
        .kind     (kind)
    );

    cfgprog_unlock #(.UNLOCK_READS(UNLOCK_READS)) u_unlock (
        .clk      (clk),
        .rst      (rst),
        .kind     (kind),
        .cfg_mode (cfg_mode)
    );

    cfgprog_timing u_timing (
        .clk     (clk),
        .rst     (rst),
        .strap_a (strap_a),
        .strap_b (strap_b),
        .capture (kind == ACC_HEAD_WR && cfg_mode),
        .wdata   (acc_wdata),
        .timing  (timing)
    );

    cfgprog_feature u_feature (
        .clk       (clk),
        .rst       (rst),
        .strap_sec (strap_sec),
        .wr        (kind == ACC_FEAT_WR),
        .wdata     (acc_wdata),
        .feat      (feat)
    );

    assign head_wr_pass = (kind == ACC_HEAD_WR) && !cfg_mode;
    assign rd_data      = (kind == ACC_FEAT_RD) ? feature_image(feat) : '0;
    assign act_clks     = timing.act;
    assign rec_clks     = timing.rec;
    assign port_sec     = feat.sec;
    assign fifo_en      = feat.fifo;
    assign prefetch_en  = feat.prefetch;

    p_pass_hold_r8: assert property (@(posedge clk) disable iff (rst)
        head_wr_pass |=> $stable(act_clks) && $stable(rec_clks));

    p_cfg_no_pass_r5: assert property (@(posedge clk) disable iff (rst)
        (cfg_mode && acc_valid && acc_write) |-> !head_wr_pass);
endmodule

// File: tb/tb_cfg_timing_prog.sv
module tb_cfg_timing_prog;
    localparam int PERIOD = 10;

    localparam int K_ACT  = 0;
    localparam int K_REC  = 1;
    localparam int K_MODE = 2;
    localparam int K_PASS = 3;
    localparam int K_RD   = 4;
    localparam int K_SEC  = 5;
    localparam int K_FIFO = 6;
    localparam int K_PREF = 7;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       strap_a = 1'b0, strap_b = 1'b0, strap_sec = 1'b0;
    logic       acc_valid = 1'b0, acc_write = 1'b0;
    logic [9:0] acc_addr = '0;
    logic [7:0] acc_wdata = '0;
    logic [7:0] rd_data;
    logic       head_wr_pass, cfg_mode, port_sec, fifo_en, prefetch_en;
    logic [4:0] act_clks, rec_clks;

    cfg_timing_prog dut (
        .clk(clk), .rst(rst), .strap_a(strap_a), .strap_b(strap_b), .strap_sec(strap_sec),
        .acc_valid(acc_valid), .acc_write(acc_write), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
        .rd_data(rd_data), .head_wr_pass(head_wr_pass), .cfg_mode(cfg_mode),
        .act_clks(act_clks), .rec_clks(rec_clks), .port_sec(port_sec),
        .fifo_en(fifo_en), .prefetch_en(prefetch_en)
    );

    always #(PERIOD/2) clk = ~clk;

    typedef struct {
        int    due;
        int    kind;
        int    exp;
        string req;
    } item_t;

    item_t q[$];
    int cyc = 0;
    int n_cmp = 0;
    int n_bad = 0;

    // bench reference model
    int m_act, m_rec, m_mode, m_cnt, m_sec, m_fifo, m_pref;

    initial forever begin
        @(posedge clk);
        cyc++;
    end

    function automatic int observe(int k);
        case (k)
            K_ACT:  return int'(act_clks);
            K_REC:  return int'(rec_clks);
            K_MODE: return int'(cfg_mode);
            K_PASS: return int'(head_wr_pass);
            K_RD:   return int'(rd_data);
            K_SEC:  return int'(port_sec);
            K_FIFO: return int'(fifo_en);
            default: return int'(prefetch_en);
        endcase
    endfunction

    // monitor: compares items that fall due in the current cycle
    initial forever begin
        @(negedge clk);
        #1;
        while (q.size() > 0 && q[0].due <= cyc) begin
            item_t it;
            int act;
            it = q.pop_front();
            n_cmp++;
            if (it.due < cyc) begin
                n_bad++;
                $display("FAIL %s: item kind %0d missed its cycle (due %0d, now %0d)",
                         it.req, it.kind, it.due, cyc);
            end else begin
                act = observe(it.kind);
                if (act != it.exp) begin
                    n_bad++;
                    $display("FAIL %s: kind %0d actual %0d expected %0d",
                             it.req, it.kind, act, it.exp);
                end
            end
        end
    end

    function automatic int strap_clks(logic a, logic b);
        case ({a, b})
            2'b00: return 15;
            2'b10: return 10;
            2'b01: return 7;
            default: return 4;
        endcase
    endfunction

    function automatic int code_clks(int c);
        return (c <= 1) ? 16 : c;
    endfunction

    task automatic push(int due, int k, int e, string req);
        item_t it;
        it.due = due; it.kind = k; it.exp = e; it.req = req;
        q.push_back(it);
    endtask

    task automatic push_state(int due, string req);
        push(due, K_ACT,  m_act,  req);
        push(due, K_REC,  m_rec,  req);
        push(due, K_MODE, m_mode, req);
        push(due, K_SEC,  m_sec,  req);
        push(due, K_FIFO, m_fifo, req);
        push(due, K_PREF, m_pref, req);
    endtask

    task automatic do_reset(logic a, logic b, logic s, string req);
        @(negedge clk);
        rst = 1'b1; acc_valid = 1'b0;
        strap_a = ~a; strap_b = ~b; strap_sec = ~s;
        @(negedge clk);
        strap_a = a; strap_b = b; strap_sec = s;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        m_act = strap_clks(a, b); m_rec = m_act;
        m_mode = 0; m_cnt = 0; m_sec = int'(s); m_fifo = 0; m_pref = 0;
        push(cyc, K_PASS, 0, req);
        push(cyc, K_RD, 0, req);
        push_state(cyc, req);
    endtask

    task automatic access(logic wr, logic [9:0] addr, logic [7:0] data, string req);
        int head, stat, e_pass, e_rd;
        @(negedge clk);
        acc_valid = 1'b1; acc_write = wr; acc_addr = addr; acc_wdata = data;
        head = m_sec ? 'h176 : 'h1F6;
        stat = m_sec ? 'h177 : 'h1F7;
        e_pass = (wr && int'(addr) == head && m_mode == 0) ? 1 : 0;
        e_rd   = (!wr && addr == 10'h3E6) ? (m_sec | (m_fifo << 2) | (m_pref << 5)) : 0;
        push(cyc, K_PASS, e_pass, req);
        push(cyc, K_RD, e_rd, req);
        if (addr == 10'h3E6 && wr) begin
            m_sec = int'(data[0]); m_fifo = int'(data[2]); m_pref = int'(data[5]);
        end
        if (m_mode == 1) begin
            m_cnt = 0;
            if (wr && int'(addr) == head) begin
                m_rec = code_clks(int'(data[7:4]));
                m_act = code_clks(int'(data[3:0]));
            end else if (!wr && int'(addr) == stat) begin
                m_mode = 0;
            end
        end else if (!wr && addr == 10'h3E6) begin
            m_cnt++;
            if (m_cnt == 4) begin m_mode = 1; m_cnt = 0; end
        end else begin
            m_cnt = 0;
        end
        push_state(cyc + 1, req);
    endtask

    task automatic idle(int n);
        repeat (n) begin
            @(negedge clk);
            acc_valid = 1'b0;
        end
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(PERIOD * 150000);
        n_bad++;
        $display("FAIL watchdog: run did not complete, actual hung expected done");
        finish_run();
    end

    initial begin
        // R1, R2: strap defaults for every combination
        do_reset(1'b1, 1'b0, 1'b0, "R1 straps 10");
        idle(1);
        do_reset(1'b0, 1'b1, 1'b0, "R1 straps 01");
        idle(1);
        do_reset(1'b1, 1'b1, 1'b1, "R2 strap_sec=1, R1 straps 11");
        idle(1);
        do_reset(1'b0, 1'b0, 1'b0, "R1 straps 00, R2 features clear");
        idle(1);

        // R8: pass-through outside configuration mode
        access(1'b1, 10'h1F6, 8'h52, "R8 head write passes, timing held");

        // R3, R4: interrupted unlock
        repeat (3) access(1'b0, 10'h3E6, 8'h00, "R3 partial unlock");
        access(1'b0, 10'h1F0, 8'h00, "R4 foreign access restarts count");
        repeat (3) access(1'b0, 10'h3E6, 8'h00, "R4 three reads after restart");
        access(1'b1, 10'h3E6, 8'h00, "R4 feature write restarts count");
        repeat (3) access(1'b0, 10'h3E6, 8'h00, "R4 still locked");
        access(1'b0, 10'h3E6, 8'h00, "R3 fourth read arms mode");

        // R5, R6: capture and decode
        access(1'b1, 10'h1F6, 8'h52, "R5 capture rec5 act2");
        access(1'b1, 10'h1F6, 8'h0F, "R6 code0 gives 16, code15 gives 15");
        access(1'b1, 10'h1F6, 8'h1E, "R6 code1 gives 16");
        access(1'b1, 10'h1F6, 8'h33, "R6 code3");
        access(1'b0, 10'h1F6, 8'h00, "R5 read of head port no capture");
        access(1'b0, 10'h1F7, 8'h00, "R7 status read exits");
        access(1'b1, 10'h1F6, 8'hA9, "R8 pass after exit");

        // R9: feature register
        access(1'b1, 10'h3E6, 8'hFF, "R9 feature write all ones");
        access(1'b0, 10'h3E6, 8'h00, "R9 readback");
        access(1'b1, 10'h3E6, 8'h24, "R9 feature write fifo+prefetch");
        access(1'b0, 10'h3E6, 8'h00, "R9 readback 24h");
        access(1'b1, 10'h3E6, 8'h01, "R9 select secondary");

        // R10: secondary channel ports
        access(1'b1, 10'h1F6, 8'h77, "R10 primary head passes? no, other channel");
        repeat (4) access(1'b0, 10'h3E6, 8'h00, "R3 unlock on secondary");
        access(1'b1, 10'h1F6, 8'h88, "R10 primary head ignored in mode");
        access(1'b0, 10'h1F7, 8'h00, "R10 primary status does not exit");
        access(1'b1, 10'h176, 8'hC4, "R5 secondary head captures");
        access(1'b0, 10'h177, 8'h00, "R7 secondary status exits");
        access(1'b1, 10'h176, 8'h22, "R8 secondary head passes");

        idle(4);
        if (q.size() != 0) begin
            n_bad++;
            $display("FAIL scoreboard: actual %0d pending expected 0", q.size());
        end
        finish_run();
    end
endmodule